// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit produces the interrupt identification byte and the interrupt request line of a 16550-style serial port. It receives one-cycle event pulses from the receiver and modem logic: a line error or break, a received character, a character timeout and a modem-signal change. It also receives the level of the transmit holding register empty flag. Each event sets a sticky pending flag. A flag is reported only while its enable bit is set. When several flags are pending, the byte shows only the one with the highest priority.

Each source has its own clear. A read of the line status register clears the line-error source. A read of the receive data register clears the received-character and timeout sources. A read of the modem status register clears the modem source. A read of the identification register clears only the transmit-empty source, and only when that source is the code the read returned. The identification byte and the request line are registered outputs.

Top module: `uart_int_ident`

## Requirements
- R1: `iir_byte[0]` is 1 when no enabled source is pending and 0 otherwise. After reset `iir_byte` is 8'h01 and `irq` is 0.
- R2: Bits 5 and 4 of `iir_byte` are always 0.
- R3: An `rd_iir` pulse clears the transmit-empty source when `iir_byte[3:0]` is 4'b0010 in that cycle. In any other cycle it leaves the source pending.
- R4: An `rd_lsr` pulse clears the pending line-error source.
- R5: An `rd_data` pulse clears both the pending received-character source and the pending timeout source.
- R6: An `rd_msr` pulse clears the pending modem-change source.
- R7: `iir_byte[7:6]` is 2'b11 in the cycle after `fifo_on` is 1, and 2'b00 in the cycle after `fifo_on` is 0.
- R8: One cycle after `ien` is 4'b0000, `iir_byte` shows no pending source and `irq` is 0. The pending flags are kept, so restoring the enables reports them again.
- R9: Enable bits are: `ien[0]` for received character and timeout, `ien[1]` for transmit empty, `ien[2]` for line error, `ien[3]` for modem change. The order from highest priority is line error, received character, timeout, transmit empty, modem change. The codes they place in `iir_byte[3:1]` are 3'b011, 3'b010, 3'b110, 3'b001 and 3'b000 respectively.
- R10: The transmit-empty source becomes pending when `tx_empty` rises. It also becomes pending when `ien[1]` rises while `tx_empty` is 1. It clears when `tx_empty` is 0.
- R11: `irq` is a register that always equals the inverse of `iir_byte[0]`.
- R12: An event pulse sets its pending flag on the next clock edge. The flag stays set until its clearing read. If the event and the clearing read happen in the same cycle, the event wins.
- R13: The identification byte is registered. Its value reflects the pending flags one edge after they change, and `ien` and `fifo_on` at the edge where it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line | input | 1 | Pulse: line error or break seen |
| ev_rxd | input | 1 | Pulse: character received |
| ev_tmo | input | 1 | Pulse: character timeout |
| ev_mdm | input | 1 | Pulse: modem signal change |
| tx_empty | input | 1 | Level: transmit holding register empty |
| ien | input | 4 | Interrupt enable bits |
| fifo_on | input | 1 | FIFOs enabled |
| rd_iir | input | 1 | Read strobe of the identification register |
| rd_lsr | input | 1 | Read strobe of the line status register |
| rd_data | input | 1 | Read strobe of the receive data register |
| rd_msr | input | 1 | Read strobe of the modem status register |
| iir_byte | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs:
- Each event input and each read strobe is a single-cycle pulse that is driven between clock edges.
- The surrounding register file raises `rd_iir` only for a real read of the identification register.
- `tx_empty` is a level that changes only between edges.

The stimulus drives every input on the falling edge and holds it for whole cycles. It applies an event and its clearing read in the same cycle only where the set-over-clear rule (R12) is under test. It toggles `tx_empty` and `ien[1]` separately, so that each re-arm path of the transmit-empty source is exercised on its own.

// File: rtl/uart_ii_pkg.sv
package uart_ii_pkg;
  localparam int IEN_W   = 4;
  localparam int ID_W    = 8;
  localparam int NUM_EV  = 4;

  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam int EV_LINE = 0;
  localparam int EV_RXD  = 1;
  localparam int EV_TMO  = 2;
  localparam int EV_MDM  = 3;

  typedef enum logic [2:0] {
    ID_MDM  = 3'b000,
    ID_TX   = 3'b001,
    ID_RXD  = 3'b010,
    ID_LINE = 3'b011,
    ID_TMO  = 3'b110
  } iid_e;
endpackage

// File: rtl/uart_ii_evt.sv
module uart_ii_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;
  logic pend_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o); // R12
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o); // R12
endmodule

// File: rtl/uart_ii_thre.sv
module uart_ii_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic en_i,
  input  logic rd_clr_i,
  output logic pend_o
);
  logic empty_q;
  logic en_q;
  logic pend_q;
  logic pend_d;
  logic arm;

  always_comb begin
    arm    = empty_i && (!empty_q || (en_i && !en_q));
    pend_d = pend_q;
    if (rd_clr_i || !empty_i) pend_d = 1'b0;
    if (arm)                  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_i;
      en_q    <= en_i;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_TX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(empty_i) && $past(rst_n)) |=> pend_o); // R10
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_i |=> !pend_o); // R10
  AST_TX_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && empty_i && $stable(empty_i) && !$rose(en_i)) |=> !pend_o); // R3
endmodule

// File: rtl/uart_ii_prio.sv
module uart_ii_prio
  import uart_ii_pkg::*;
(
  input  logic [NUM_EV-1:0] ev_pend_i,
  input  logic              tx_pend_i,
  input  logic [IEN_W-1:0]  ien_i,
  input  logic              fifo_on_i,
  output logic [ID_W-1:0]   ident_o
);
  iid_e code;
  logic none;

  always_comb begin
    none = 1'b0;
    code = ID_MDM;
    if (ev_pend_i[EV_LINE] && ien_i[EN_LINE])     code = ID_LINE;
    else if (ev_pend_i[EV_RXD] && ien_i[EN_RX])   code = ID_RXD;
    else if (ev_pend_i[EV_TMO] && ien_i[EN_RX])   code = ID_TMO;
    else if (tx_pend_i && ien_i[EN_TX])           code = ID_TX;
    else if (ev_pend_i[EV_MDM] && ien_i[EN_MDM])  code = ID_MDM;
    else                                          none = 1'b1;
    ident_o      = '0;
    ident_o[0]   = none;
    ident_o[3:1] = none ? 3'b000 : code;
    ident_o[7:6] = {2{fifo_on_i}};
  end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_ii_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_line,
  input  logic             ev_rxd,
  input  logic             ev_tmo,
  input  logic             ev_mdm,
  input  logic             tx_empty,
  input  logic [IEN_W-1:0] ien,
  input  logic             fifo_on,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_data,
  input  logic             rd_msr,
  output logic [ID_W-1:0]  iir_byte,
  output logic             irq
);
  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [NUM_EV-1:0] ev_set;
  logic [NUM_EV-1:0] ev_clr;
  logic [NUM_EV-1:0] ev_pend;
  logic              tx_pend;
  logic              tx_rd_clr;
  logic [ID_W-1:0]   ident_d;
  logic [ID_W-1:0]   ident_q;
  logic              irq_d;
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  assign ev_set = {ev_mdm, ev_tmo, ev_rxd, ev_line};
  assign ev_clr = {rd_msr, rd_data, rd_data, rd_lsr};

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evt
    uart_ii_evt u_evt (
      .clk    (clk),
      .rst_n  (srst_n),
      .set_i  (ev_set[i]),
      .clr_i  (ev_clr[i]),
      .pend_o (ev_pend[i])
    );
  end

  assign tx_rd_clr = rd_iir && (ident_q[3:0] == {ID_TX, 1'b0});

  uart_ii_thre u_thre (
    .clk      (clk),
    .rst_n    (srst_n),
    .empty_i  (tx_empty),
    .en_i     (ien[EN_TX]),
    .rd_clr_i (tx_rd_clr),
    .pend_o   (tx_pend)
  );

  uart_ii_prio u_prio (
    .ev_pend_i (ev_pend),
    .tx_pend_i (tx_pend),
    .ien_i     (ien),
    .fifo_on_i (fifo_on),
    .ident_o   (ident_d)
  );

  assign irq_d = !ident_d[0];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ident_q <= 8'h01;
      irq_q   <= 1'b0;
    end else begin
      ident_q <= ident_d;
      irq_q   <= irq_d;
    end
  end

  assign iir_byte = ident_q;
  assign irq      = irq_q;

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    iir_byte[5:4] == 2'b00); // R2
  AST_IRQ_INV: assert property (@(posedge clk) disable iff (!srst_n)
    irq == !iir_byte[0]); // R11
  AST_NOEN_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (ien == '0) |=> (iir_byte[0] && !irq)); // R8
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!srst_n)
    fifo_on |=> (iir_byte[7:6] == 2'b11)); // R7
  AST_LSR_CLR: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_lsr && !ev_line) |=> !ev_pend[EV_LINE]); // R4
  AST_DATA_CLR: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data && !ev_rxd && !ev_tmo) |=> !(ev_pend[EV_RXD] || ev_pend[EV_TMO])); // R5
  AST_MSR_CLR: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_msr && !ev_mdm) |=> !ev_pend[EV_MDM]); // R6
endmodule

// File: tb/uart_int_ident_tb.sv
module uart_int_ident_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_line = 0, ev_rxd = 0, ev_tmo = 0, ev_mdm = 0;
  logic       tx_empty = 0, fifo_on = 0;
  logic [3:0] ien = 4'h0;
  logic       rd_iir = 0, rd_lsr = 0, rd_data = 0, rd_msr = 0;
  logic [7:0] iir_byte;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_int_ident u_dut (
    .clk(clk), .rst_n(rst_n), .ev_line(ev_line), .ev_rxd(ev_rxd),
    .ev_tmo(ev_tmo), .ev_mdm(ev_mdm), .tx_empty(tx_empty), .ien(ien),
    .fifo_on(fifo_on), .rd_iir(rd_iir), .rd_lsr(rd_lsr),
    .rd_data(rd_data), .rd_msr(rd_msr), .iir_byte(iir_byte), .irq(irq)
  );

  // behavioural reference model
  bit   m_line, m_rxd, m_tmo, m_mdm, m_tx, m_empty_d, m_en_d;
  logic [7:0] m_iir = 8'h01;
  bit   m_irq;
  int   rst_cnt = 0;

  always @(posedge clk) begin
    logic [7:0] nx;
    bit txclr;
    if (!rst_n || rst_cnt < 2) begin
      if (!rst_n) rst_cnt = 0; else rst_cnt++;
      m_line = 0; m_rxd = 0; m_tmo = 0; m_mdm = 0; m_tx = 0;
      m_empty_d = 0; m_en_d = 0; m_iir = 8'h01; m_irq = 0;
    end else begin
      nx = 8'h01;
      if (m_line && ien[2])     nx = 8'h06;
      else if (m_rxd && ien[0]) nx = 8'h04;
      else if (m_tmo && ien[0]) nx = 8'h0C;
      else if (m_tx && ien[1])  nx = 8'h02;
      else if (m_mdm && ien[3]) nx = 8'h00;
      if (fifo_on) nx[7:6] = 2'b11;
      txclr = rd_iir && (m_iir[3:0] == 4'h2);
      if (rd_lsr) m_line = 0;
      if (ev_line) m_line = 1;
      if (rd_data) begin m_rxd = 0; m_tmo = 0; end
      if (ev_rxd) m_rxd = 1;
      if (ev_tmo) m_tmo = 1;
      if (rd_msr) m_mdm = 0;
      if (ev_mdm) m_mdm = 1;
      if (txclr || !tx_empty) m_tx = 0;
      if (tx_empty && (!m_empty_d || (ien[1] && !m_en_d))) m_tx = 1;
      m_empty_d = tx_empty;
      m_en_d = ien[1];
      m_iir = nx;
      m_irq = !nx[0];
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_chk++;
      if (iir_byte !== m_iir) begin
        n_bad++;
        $display("FAIL R13 cycle compare iir_byte actual %h expected %h", iir_byte, m_iir);
      end
      n_chk++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL R11 cycle compare irq actual %b expected %b", irq, m_irq);
      end
      n_chk++;
      if (iir_byte[5:4] !== 2'b00) begin
        n_bad++;
        $display("FAIL R2 bits 5:4 actual %b expected 00", iir_byte[5:4]);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(logic [7:0] exp, string tag);
    n_chk++;
    if (iir_byte !== exp || irq !== !exp[0]) begin
      n_bad++;
      $display("FAIL %s iir_byte/irq actual %h/%b expected %h/%b",
               tag, iir_byte, irq, exp, !exp[0]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual hung expected finish");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
      end
    join_none

    tick(3);
    rst_n = 1;
    tick(4);
    chk(8'h01, "R1 reset state");

    ien = 4'hF; tick(2);
    ev_mdm = 1; tick(); ev_mdm = 0; tick();
    chk(8'h00, "R6 modem pending");
    rd_msr = 1; tick(); rd_msr = 0; tick();
    chk(8'h01, "R6 modem cleared by msr read");

    ev_line = 1; ev_rxd = 1; tick(); ev_line = 0; ev_rxd = 0; tick();
    chk(8'h06, "R9 line above rx data");
    rd_iir = 1; tick(); rd_iir = 0; tick();
    chk(8'h06, "R3 iir read leaves line source");
    rd_lsr = 1; tick(); rd_lsr = 0; tick();
    chk(8'h04, "R4 line cleared, rx data shown");
    rd_data = 1; tick(); rd_data = 0; tick();
    chk(8'h01, "R5 rx data cleared");

    ev_tmo = 1; tick(); ev_tmo = 0; tick();
    chk(8'h0C, "R9 timeout code");
    rd_data = 1; tick(); rd_data = 0; tick();
    chk(8'h01, "R5 timeout cleared by data read");

    tx_empty = 1; tick(2);
    chk(8'h02, "R10 tx armed on empty rise");
    rd_iir = 1; tick(); rd_iir = 0; tick();
    chk(8'h01, "R3 tx cleared by iir read");
    ien = 4'hD; tick(); ien = 4'hF; tick(2);
    chk(8'h02, "R10 tx re-armed by enable rise");

    ev_mdm = 1; tick(); ev_mdm = 0; tick();
    chk(8'h02, "R9 tx above modem");
    ien = 4'h0; tick();
    chk(8'h01, "R8 all enables off");
    ien = 4'hF; tick();
    chk(8'h02, "R8 flags kept while masked");

    fifo_on = 1; tick();
    chk(8'hC2, "R7 fifo bits set");
    fifo_on = 0; tick();
    chk(8'h02, "R7 fifo bits clear");

    tx_empty = 0; tick(2);
    chk(8'h00, "R10 tx dropped when not empty");
    rd_msr = 1; tick(); rd_msr = 0; tick();
    ev_mdm = 1; rd_msr = 1; tick(); ev_mdm = 0; rd_msr = 0; tick();
    chk(8'h00, "R12 set beats clear");
    rd_msr = 1; tick(); rd_msr = 0; tick(2);
    chk(8'h01, "R12 cleared later");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule